// File: doc/BRIEF.md
# Clock Synthesizer Configuration Register Bank

This block holds the configuration bytes of a clock synthesizer behind a simple synchronous byte port: an index, a write strobe with write data, and a read strobe that returns one byte on the following cycle. Some indexes act on the synthesizer as soon as they are written. The loop-control byte, the two feedback-divider bytes and the delay-line resolution byte are double-buffered. A write to one of them only updates a programmed (shadow) copy. The copy that drives the hardware (the working copy) changes only when a command is written to a dedicated write-only command index.

Index 8 is the command index, and each nibble controls one group. If the upper nibble is 0x5, the bank copies indexes 1 to 3 into their working registers and pulses `pll_load` for one clock. If the lower nibble is 0xA, it copies index 5 and pulses `dpa_load`. A value of 0x5A does both. Any other nibble value does nothing for its group.

Three read-only indexes identify the part and report lock status: 0x10 returns the version, 0x11 returns the revision, and 0x12 returns the lock flags. The serial bus slave that feeds the port sits outside this block, and so do the PLL and the delay line.

Top module: `dbuf_cfg_bank`

## Requirements
- R1: After reset the following values apply, both at the outputs and on readback. Index 0 is 0x41 and index 1 is 0x00. The feedback divider is 0xFFF, from index 2 = 0xFF and index 3 = 0x0F. Index 4 is 0x80, index 5 is 0x03, index 6 is 0x1F and index 7 is 0x80. `pll_load` and `dpa_load` are low.
- R2: A read strobe sampled at a clock edge puts the addressed byte on `rdata` after that edge. `rdata` holds its value in every cycle that has no read strobe.
- R3: Indexes 0, 4, 6 and 7 are single-buffered. A write to one of them drives its output from the edge that samples the write.
- R4: Indexes 1, 2 and 3 are double-buffered. A write to one of them changes its readback at once, and `loop_ctl` and `fb_div` stay unchanged until a PLL load.
- R5: Index 8 is the command index. A write with upper nibble 0x5 loads the working copies of indexes 1 to 3 into `loop_ctl` and `fb_div` (`fb_div` = {index3[3:0], index2}) on the edge after the write. On that same edge `pll_load` goes high, and it stays high for that one cycle only.
- R6: Index 5 is double-buffered. A write to index 8 with lower nibble 0xA loads `dpa_res` from index 5 bits 1:0 and pulses `dpa_load` for one cycle, with the same timing as the PLL load in R5. Until that load, `dpa_res` does not change.
- R7: A command of 0x5A fires both loads in the same cycle. A nibble value other than its command code leaves that group's pulse low and its working registers unchanged.
- R8: Reserved bits read back as zero whatever was written. The read masks are 0x37 for index 1, 0x0F for index 3, 0xBF for index 4 and 0x03 for index 5. Indexes 0, 2, 6 and 7 use all eight bits.
- R9: Index 0x10 reads the VERSION parameter (default 0x18) and index 0x11 reads the REVISION parameter (default 0x01). Writes to these indexes are ignored.
- R10: Index 0x12 reads {6'b0, `pll_lock_in`, `dpa_lock_in`}. Bit 0 is the DPA lock flag and bit 1 is the PLL lock flag.
- R11: Index 8 reads as 0x00. Unmapped indexes read 0x00, and a write to one of them changes no output and no readback.
- R12: `dpa_len` decodes the working resolution field as 0→16, 1→32, 2→0 (reserved) and 3→64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register index |
| wdata | input | 8 | Write data |
| pll_lock_in | input | 1 | PLL lock flag from the loop |
| dpa_lock_in | input | 1 | Delay-line lock flag |
| rdata | output | 8 | Registered read data |
| in_ctl | output | 8 | Input-control byte (index 0) |
| loop_ctl | output | 8 | Working loop-control byte |
| fb_div | output | 12 | Working feedback divider |
| dpa_ofs | output | 8 | Phase offset and loop-filter byte (index 4) |
| dpa_res | output | 2 | Working delay-line resolution code |
| dpa_len | output | 7 | Decoded delay-element count |
| out_ctl | output | 8 | Output-enable byte (index 6) |
| osc_ctl | output | 8 | Oscillator-divider byte (index 7) |
| pll_load | output | 1 | One-cycle PLL load pulse |
| dpa_load | output | 1 | One-cycle delay-line load pulse |

## Verification
The properties assume that `wr_en`, `addr` and `wdata` are settled at each rising edge, and that a write and a read never share a cycle. They also assume that the working outputs move only on a load pulse, so they require reset to be the only other source of change. The stimulus drives every strobe from the falling edge, keeps reads and writes in separate cycles, and always lowers a strobe one cycle after raising it. It also changes the lock inputs only in cycles without a read.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int DW   = 8;
  localparam int NREG = 8;

  localparam logic [7:0] IDX_CMD  = 8'h08;
  localparam logic [7:0] IDX_VER  = 8'h10;
  localparam logic [7:0] IDX_REV  = 8'h11;
  localparam logic [7:0] IDX_STAT = 8'h12;

  localparam logic [3:0] CMD_PLL = 4'h5;
  localparam logic [3:0] CMD_DPA = 4'hA;

  // writable bits per stored index
  function automatic logic [DW-1:0] reg_mask(input int idx);
    case (idx)
      1:       reg_mask = 8'h37;
      3:       reg_mask = 8'h0F;
      4:       reg_mask = 8'hBF;
      5:       reg_mask = 8'h03;
      default: reg_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_reset(input int idx);
    case (idx)
      0:       reg_reset = 8'h41;
      2:       reg_reset = 8'hFF;
      3:       reg_reset = 8'h0F;
      4:       reg_reset = 8'h80;
      5:       reg_reset = 8'h03;
      6:       reg_reset = 8'h1F;
      7:       reg_reset = 8'h80;
      default: reg_reset = 8'h00;
    endcase
  endfunction

  function automatic logic [6:0] dpa_len_of(input logic [1:0] code);
    case (code)
      2'd0:    dpa_len_of = 7'd16;
      2'd1:    dpa_len_of = 7'd32;
      2'd3:    dpa_len_of = 7'd64;
      default: dpa_len_of = 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_shadow_regs.sv
module cfg_shadow_regs
  import cfg_bank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                addr,
  input  logic [DW-1:0]             wdata,
  output logic [NREG-1:0][DW-1:0]   shadow_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = reg_mask(i);
    localparam logic [DW-1:0] RSTV = reg_reset(i);
    logic          wr_hit;
    logic [DW-1:0] d;

    always_comb begin
      wr_hit = wr_en && (addr == 8'(i));
      d      = wdata & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow_q[i] <= RSTV;
      else if (wr_hit) shadow_q[i] <= d;
    end
  end
endmodule

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic          pll_hit,
  output logic          dpa_hit,
  output logic          pll_load_q,
  output logic          dpa_load_q
);
  always_comb begin
    pll_hit = wr_en && (addr == IDX_CMD) && (wdata[7:4] == CMD_PLL);
    dpa_hit = wr_en && (addr == IDX_CMD) && (wdata[3:0] == CMD_DPA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_load_q <= 1'b0;
      dpa_load_q <= 1'b0;
    end else begin
      pll_load_q <= pll_hit;
      dpa_load_q <= dpa_hit;
    end
  end
endmodule

// File: rtl/cfg_working_regs.sv
module cfg_working_regs
  import cfg_bank_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0][DW-1:0] shadow_q,
  input  logic                    pll_hit,
  input  logic                    dpa_hit,
  output logic [DW-1:0]           loop_q,
  output logic [11:0]             fbdiv_q,
  output logic [1:0]              res_q
);
  localparam logic [DW-1:0] LOOP_RST = reg_reset(1);
  localparam logic [11:0]   FB_RST   = {reg_reset(3)[3:0], reg_reset(2)};
  localparam logic [1:0]    RES_RST  = reg_reset(5)[1:0];

  logic [DW-1:0] loop_d;
  logic [11:0]   fbdiv_d;
  logic [1:0]    res_d;

  always_comb begin
    loop_d  = shadow_q[1];
    fbdiv_d = {shadow_q[3][3:0], shadow_q[2]};
    res_d   = shadow_q[5][1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q  <= LOOP_RST;
      fbdiv_q <= FB_RST;
    end else if (pll_hit) begin
      loop_q  <= loop_d;
      fbdiv_q <= fbdiv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= RES_RST;
    else if (dpa_hit) res_q <= res_d;
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_bank_pkg::*;
#(
  parameter logic [7:0] VERSION  = 8'h18,
  parameter logic [7:0] REVISION = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [7:0]              addr,
  input  logic [NREG-1:0][DW-1:0] shadow_q,
  input  logic                    pll_lock_in,
  input  logic                    dpa_lock_in,
  output logic [DW-1:0]           rdata_q
);
  logic [DW-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (addr < 8'(NREG))        rd_d = shadow_q[addr[2:0]];
    else if (addr == IDX_VER)   rd_d = VERSION;
    else if (addr == IDX_REV)   rd_d = REVISION;
    else if (addr == IDX_STAT)  rd_d = {6'b0, pll_lock_in, dpa_lock_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end
endmodule

// File: rtl/dbuf_cfg_bank.sv
module dbuf_cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter logic [7:0] VERSION  = 8'h18,
  parameter logic [7:0] REVISION = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        pll_lock_in,
  input  logic        dpa_lock_in,
  output logic [7:0]  rdata,
  output logic [7:0]  in_ctl,
  output logic [7:0]  loop_ctl,
  output logic [11:0] fb_div,
  output logic [7:0]  dpa_ofs,
  output logic [1:0]  dpa_res,
  output logic [6:0]  dpa_len,
  output logic [7:0]  out_ctl,
  output logic [7:0]  osc_ctl,
  output logic        pll_load,
  output logic        dpa_load
);
  logic [NREG-1:0][DW-1:0] shadow_q;
  logic pll_hit, dpa_hit;

  cfg_shadow_regs u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .shadow_q(shadow_q)
  );

  cfg_cmd_decode u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pll_hit(pll_hit), .dpa_hit(dpa_hit),
    .pll_load_q(pll_load), .dpa_load_q(dpa_load)
  );

  cfg_working_regs u_work (
    .clk(clk), .rst_n(rst_n), .shadow_q(shadow_q),
    .pll_hit(pll_hit), .dpa_hit(dpa_hit),
    .loop_q(loop_ctl), .fbdiv_q(fb_div), .res_q(dpa_res)
  );

  cfg_read_mux #(.VERSION(VERSION), .REVISION(REVISION)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .shadow_q(shadow_q), .pll_lock_in(pll_lock_in),
    .dpa_lock_in(dpa_lock_in), .rdata_q(rdata)
  );

  always_comb begin
    in_ctl  = shadow_q[0];
    dpa_ofs = shadow_q[4];
    out_ctl = shadow_q[6];
    osc_ctl = shadow_q[7];
    dpa_len = dpa_len_of(dpa_res);
  end
endmodule

// File: rtl/dbuf_cfg_bank_chk.sv
module dbuf_cfg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [7:0]  loop_ctl,
  input logic [11:0] fb_div,
  input logic [1:0]  dpa_res,
  input logic        pll_load,
  input logic        dpa_load
);
  // R5
  pll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h08 && wdata[7:4] == 4'h5) |=> pll_load);
  // R7
  pll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h08 && wdata[7:4] == 4'h5) |=> !pll_load);
  // R6
  dpa_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h08 && wdata[3:0] == 4'hA) |=> dpa_load);
  // R7
  dpa_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h08 && wdata[3:0] == 4'hA) |=> !dpa_load);
  // R4
  fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_load |-> ($stable(fb_div) && $stable(loop_ctl)));
  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dpa_load |-> $stable(dpa_res));
  // R10
  stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h12) |=> (rdata[7:2] == 6'd0));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind dbuf_cfg_bank dbuf_cfg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .loop_ctl(loop_ctl), .fb_div(fb_div),
  .dpa_res(dpa_res), .pll_load(pll_load), .dpa_load(dpa_load)
);

// File: tb/dbuf_cfg_bank_tb_top.sv
module dbuf_cfg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = 8'h00, wdata = 8'h00;
  logic        pll_lock_in = 1'b0, dpa_lock_in = 1'b0;
  logic [7:0]  rdata, in_ctl, loop_ctl, dpa_ofs, out_ctl, osc_ctl;
  logic [11:0] fb_div;
  logic [1:0]  dpa_res;
  logic [6:0]  dpa_len;
  logic        pll_load, dpa_load;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;

  always #4 clk = ~clk;

  dbuf_cfg_bank dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // monitor: a read sampled at an edge is compared at the next falling edge
  always @(posedge clk) rd_pend <= rd_en && rst_n;
  initial forever begin
    @(negedge clk);
    if (rd_pend) begin
      if (exp_q.size() == 0) chk("R2 (unexpected read)", 1, 0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_ctl", in_ctl, 8'h41);   chk("R1 loop_ctl", loop_ctl, 8'h00);
    chk("R1 fb_div", fb_div, 12'hFFF); chk("R1 dpa_ofs", dpa_ofs, 8'h80);
    chk("R1 dpa_res", dpa_res, 2'd3);  chk("R1 out_ctl", out_ctl, 8'h1F);
    chk("R1 osc_ctl", osc_ctl, 8'h80); chk("R1 pulses", {pll_load, dpa_load}, 2'b00);
    chk("R12 len 64", dpa_len, 7'd64);
    rd(8'h00, 8'h41, "R1 rd0"); rd(8'h01, 8'h00, "R1 rd1");
    rd(8'h02, 8'hFF, "R1 rd2"); rd(8'h03, 8'h0F, "R1 rd3");
    rd(8'h04, 8'h80, "R1 rd4"); rd(8'h05, 8'h03, "R1 rd5");
    rd(8'h06, 8'h1F, "R1 rd6"); rd(8'h07, 8'h80, "R1 rd7");
    rd(8'h10, 8'h18, "R9 version"); rd(8'h11, 8'h01, "R9 revision");
    rd(8'h08, 8'h00, "R11 cmd index"); rd(8'h20, 8'h00, "R11 unmapped");
    // R3 single-buffered
    wr(8'h00, 8'hA5); chk("R3 in_ctl", in_ctl, 8'hA5);
    wr(8'h06, 8'h2C); chk("R3 out_ctl", out_ctl, 8'h2C);
    wr(8'h07, 8'h13); chk("R3 osc_ctl", osc_ctl, 8'h13);
    wr(8'h04, 8'hFF); chk("R8 dpa_ofs mask", dpa_ofs, 8'hBF);
    // R4 double-buffered PLL group
    wr(8'h02, 8'h34); wr(8'h03, 8'hF2); wr(8'h01, 8'hFF);
    chk("R4 fb_div held", fb_div, 12'hFFF); chk("R4 loop held", loop_ctl, 8'h00);
    rd(8'h03, 8'h02, "R8 rd3 mask"); rd(8'h01, 8'h37, "R8 rd1 mask");
    rd(8'h02, 8'h34, "R4 rd2 shadow");
    // R7 non-command nibbles
    wr(8'h08, 8'h6B);
    chk("R7 no pulses", {pll_load, dpa_load}, 2'b00); chk("R7 fb_div", fb_div, 12'hFFF);
    // R5 PLL load
    wr(8'h08, 8'h5B);
    chk("R5 pll_load", pll_load, 1'b1); chk("R7 dpa quiet", dpa_load, 1'b0);
    chk("R5 fb_div", fb_div, 12'h234);  chk("R5 loop_ctl", loop_ctl, 8'h37);
    @(negedge clk); chk("R5 pulse width", pll_load, 1'b0);
    // R6 DPA load
    wr(8'h05, 8'hFD); rd(8'h05, 8'h01, "R8 rd5 mask");
    chk("R6 res held", dpa_res, 2'd3);
    wr(8'h08, 8'h7A);
    chk("R6 dpa_load", dpa_load, 1'b1); chk("R7 pll quiet", pll_load, 1'b0);
    chk("R6 dpa_res", dpa_res, 2'd1);   chk("R12 len 32", dpa_len, 7'd32);
    @(negedge clk); chk("R6 pulse width", dpa_load, 1'b0);
    // R12 reserved code, then R7 both
    wr(8'h05, 8'h02); wr(8'h08, 8'h0A); chk("R12 len reserved", dpa_len, 7'd0);
    wr(8'h05, 8'h00); wr(8'h02, 8'h56); wr(8'h08, 8'h5A);
    chk("R7 both pulses", {pll_load, dpa_load}, 2'b11);
    chk("R12 len 16", dpa_len, 7'd16); chk("R7 fb_div", fb_div, 12'h256);
    // R9 / R11 ignored writes
    wr(8'h10, 8'h00); rd(8'h10, 8'h18, "R9 version after write");
    wr(8'h20, 8'hFF);
    chk("R11 outputs kept", {in_ctl, out_ctl, osc_ctl, dpa_ofs}, 32'hA52C13BF);
    rd(8'h20, 8'h00, "R11 unmapped after write");
    // R10 lock status
    @(negedge clk); pll_lock_in = 1'b1; dpa_lock_in = 1'b0;
    rd(8'h12, 8'h02, "R10 pll lock");
    @(negedge clk); pll_lock_in = 1'b0; dpa_lock_in = 1'b1;
    rd(8'h12, 8'h01, "R10 dpa lock");
    // R2 hold without strobe
    repeat (2) @(negedge clk); chk("R2 rdata held", rdata, 8'h01);
    @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule